// File: doc/BRIEF.md
# Symmetric PWM Time-Base with Compare Channel

This block generates one raw PWM signal from a prescaled time-base counter and a single compare channel. The counter can count up and wrap, count down and reload, or count up and down between zero and a period value (symmetric, centre-aligned PWM). It can also be frozen. Every time the counter arrives at a value equal to the active compare, an action qualifier sets, clears or toggles the output. The action for an arrival while counting up is chosen separately from the action for an arrival while counting down.

The block is configured through a single-cycle register write port. It has five registers: period at address 0, compare A at address 1, compare B at address 2, control at address 3 and prescale at address 4. Period and compare A can be double-buffered. In that case a write lands in a shadow copy, and the shadow is moved into the active register on a selected counter event, so a new duty cycle never splits a PWM period. The block also produces a sync-out pulse for downstream time-bases, single-clock zero and period strobes, and the direction of the next count step. Compare B is always written directly; its only use is as one of the sync-out sources.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter mode is freeze (code 11), the sync-out select is disabled (code 11), prescale is /1, period, compare and counter are 0, and pwm_a, sync_out, zero_hit and prd_hit are 0. No strobe appears until the mode is changed.
- R2: Control bits [1:0] pick the counter mode: 00 up (wrap to 0 after reaching period), 01 down (reload period after reaching 0), 10 up-down, 11 freeze (counter holds). A new mode is used from the tick after the write clock, and the count continues from its current value.
- R3: Control bit 2 = 0 sends period writes to a shadow copy, which becomes active on the tick where the counter enters 0. Control bit 2 = 1 writes the active period directly.
- R4: Control bit 5 = 1 writes compare A directly into the active register, and the load-point field has no effect. Control bit 5 = 0 sends the write to a shadow copy. That copy loads on the load point in control bits [4:3]: 00 counter enters 0, 01 counter enters period, 10 either event, 11 never.
- R5: When the counter enters the active compare A value, pwm_a is updated. If the step was upward, the action comes from control [7:6]; if it was downward, from control [9:8]. Action codes: 00 none, 01 drive low, 10 drive high, 11 toggle.
- R6: In up-down mode the counter turns down at the period and up at 0. count_up gives the direction of the next step (1 up). zero_hit and prd_hit are single-clock pulses that appear in the clock where the counter takes the value 0 or the period.
- R7: In up-down mode with set-on-up and clear-on-down, a compare of 0 gives a constant low output, a compare equal to the period gives a constant high output, and a compare above the period leaves the output unchanged. None of these cases glitches at a turnaround. Otherwise the output is high for 2*(period-compare) of every 2*period ticks.
- R8: Prescale bits [2:0] select a coarse divider: 000 gives /1, and code n>0 gives /2n. Bits [5:3] select a fine divider of /2^code. One counter tick occurs every coarse*fine clocks.
- R9: Control bits [11:10] select sync_out: 00 passes sync_in through, 01 gives the zero strobe, 10 gives a single-clock pulse when the counter enters compare B, and 11 holds it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 period, 1 compare A, 2 compare B, 3 control, 4 prescale) |
| wr_data | input | CW | Register write data |
| sync_in | input | 1 | Sync input from an upstream time-base |
| pwm_a | output | 1 | Raw PWM output |
| sync_out | output | 1 | Selected sync output |
| zero_hit | output | 1 | Counter entered zero |
| prd_hit | output | 1 | Counter entered period |
| count_up | output | 1 | Direction of the next count step |

## Verification
The bench measures the time spent high over whole up-down periods and compares it with the expected high time for several period and compare pairs. These pairs include compare at 0, at the period and above it, where a design with a turnaround glitch or a misplaced match would gain or lose ticks. It writes a new compare or period exactly on a zero strobe and checks the next windows. A design that loaded its shadows at the wrong event, or ignored the freeze load point, would give asymmetric duty or a period of the wrong length. It freezes the counter one step after zero and times the resume to the next period strobe; a design that restarted from zero, or applied the mode on the write clock, would be off by at least one clock. It also checks the zero-to-zero distance under a combined prescale and that each strobe lasts exactly one clock.

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          sync_in,
  output logic          pwm_a,
  output logic          sync_out,
  output logic          zero_hit,
  output logic          prd_hit,
  output logic          count_up
);

  localparam int PSW = 12;
  localparam logic [2:0] A_PRD = 3'd0, A_CMPA = 3'd1, A_CMPB = 3'd2, A_CTRL = 3'd3, A_PSC = 3'd4;
  localparam logic [11:0] CTRL_RST = 12'hC03;

  logic [CW-1:0]  cnt_q, nxt, prd_act, prd_sh, cmp_act, cmp_sh, cmpb_q;
  logic [11:0]    ctrl_q;
  logic [5:0]     psc_q;
  logic [PSW-1:0] pcnt_q, div;
  logic [3:0]     hs_div;
  logic [7:0]     lo_div;
  logic           dir_q, pwm_q, cmpb_hit, eff_up, tick, step;
  logic           zero_ev, prd_ev, cmpa_ev, cmpb_ev, cmp_ld, pwm_d;
  logic [1:0]     mode, cmp_lp, act_up, act_dn, sync_sel, act;
  logic           prd_imm, cmp_imm;
  logic           wr_prd, wr_cmp;

  assign mode     = ctrl_q[1:0];
  assign prd_imm  = ctrl_q[2];
  assign cmp_lp   = ctrl_q[4:3];
  assign cmp_imm  = ctrl_q[5];
  assign act_up   = ctrl_q[7:6];
  assign act_dn   = ctrl_q[9:8];
  assign sync_sel = ctrl_q[11:10];

  assign wr_prd = wr_en && (wr_addr == A_PRD);
  assign wr_cmp = wr_en && (wr_addr == A_CMPA);

  assign hs_div = (psc_q[2:0] == 3'd0) ? 4'd1 : {psc_q[2:0], 1'b0};
  assign lo_div = 8'd1 << psc_q[5:3];
  assign div    = PSW'(hs_div) * PSW'(lo_div);
  assign tick   = (pcnt_q >= div - 1'b1);
  assign step   = tick && (mode != 2'b11);

  always_comb begin
    eff_up = dir_q;
    nxt    = cnt_q;
    case (mode)
      2'b00: begin
        eff_up = 1'b1;
        nxt    = (cnt_q >= prd_act) ? '0 : cnt_q + 1'b1;
      end
      2'b01: begin
        eff_up = 1'b0;
        nxt    = (cnt_q == '0) ? prd_act : cnt_q - 1'b1;
      end
      2'b10: begin
        if (prd_act == '0) begin
          eff_up = 1'b1;
          nxt    = '0;
        end else begin
          if (cnt_q == '0)            eff_up = 1'b1;
          else if (cnt_q >= prd_act)  eff_up = 1'b0;
          nxt = eff_up ? cnt_q + 1'b1 : cnt_q - 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign zero_ev = step && (nxt == '0);
  assign prd_ev  = step && (nxt == prd_act);
  assign cmpa_ev = step && (nxt == cmp_act);
  assign cmpb_ev = step && (nxt == cmpb_q);

  assign act = eff_up ? act_up : act_dn;
  always_comb begin
    case (act)
      2'b01:   pwm_d = 1'b0;
      2'b10:   pwm_d = 1'b1;
      2'b11:   pwm_d = ~pwm_q;
      default: pwm_d = pwm_q;
    endcase
  end

  always_comb begin
    case (cmp_lp)
      2'b00:   cmp_ld = zero_ev;
      2'b01:   cmp_ld = prd_ev;
      2'b10:   cmp_ld = zero_ev || prd_ev;
      default: cmp_ld = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt_q   <= '0;
      cnt_q    <= '0;
      dir_q    <= 1'b1;
      pwm_q    <= 1'b0;
      zero_hit <= 1'b0;
      prd_hit  <= 1'b0;
      cmpb_hit <= 1'b0;
      prd_act  <= '0;
      prd_sh   <= '0;
      cmp_act  <= '0;
      cmp_sh   <= '0;
      cmpb_q   <= '0;
      ctrl_q   <= CTRL_RST;
      psc_q    <= '0;
    end else begin
      pcnt_q <= tick ? '0 : pcnt_q + 1'b1;
      if (step) begin
        cnt_q <= nxt;
        dir_q <= eff_up;
      end
      zero_hit <= zero_ev;
      prd_hit  <= prd_ev;
      cmpb_hit <= cmpb_ev;
      if (cmpa_ev) pwm_q <= pwm_d;

      if (wr_prd) prd_sh <= wr_data;
      if (wr_prd && prd_imm)        prd_act <= wr_data;
      else if (zero_ev && !prd_imm) prd_act <= prd_sh;

      if (wr_cmp) cmp_sh <= wr_data;
      if (wr_cmp && cmp_imm)        cmp_act <= wr_data;
      else if (cmp_ld && !cmp_imm)  cmp_act <= cmp_sh;

      if (wr_en && wr_addr == A_CMPB) cmpb_q <= wr_data;
      if (wr_en && wr_addr == A_CTRL) ctrl_q <= wr_data[11:0];
      if (wr_en && wr_addr == A_PSC)  psc_q  <= wr_data[5:0];
    end
  end

  assign pwm_a    = pwm_q;
  assign count_up = eff_up;

  always_comb begin
    case (sync_sel)
      2'b00:   sync_out = sync_in;
      2'b01:   sync_out = zero_hit;
      2'b10:   sync_out = cmpb_hit;
      default: sync_out = 1'b0;
    endcase
  end

  assert_freeze_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'b11) |-> (cnt_q == $past(cnt_q)));

  assert_zero_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |-> (cnt_q == '0));

  assert_updown_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'b10 && $past(cnt_q <= prd_act) && prd_act == $past(prd_act)) |-> (cnt_q <= prd_act));

  assert_prd_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!prd_imm) && !$past(zero_ev)) |-> (prd_act == $past(prd_act)));

  assert_cmp_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cmp_imm && cmp_lp == 2'b11 && !wr_cmp)) |-> (cmp_act == $past(cmp_act)));

endmodule

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam int VEC [NV][3] = '{
    '{10, 4, 12}, '{10, 0, 0}, '{10, 10, 20}, '{8, 1, 14},
    '{16, 8, 16}, '{5, 3, 4},  '{20, 19, 2},  '{12, 6, 12}};

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, sync_in = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic pwm_a, sync_out, zero_hit, prd_hit, count_up;
  int nchk = 0, nfail = 0;

  pwm_timebase #(.CW(16)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_in(sync_in), .pwm_a(pwm_a), .sync_out(sync_out), .zero_hit(zero_hit),
    .prd_hit(prd_hit), .count_up(count_up));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] mk_ctrl(int md, int pimm, int lp, int cimm, int au, int ad, int ss);
    return 16'((md & 3) | ((pimm & 1) << 2) | ((lp & 3) << 3) | ((cimm & 1) << 5) |
               ((au & 3) << 6) | ((ad & 3) << 8) | ((ss & 3) << 10));
  endfunction

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_zero();
    @(negedge clk);
    while (!zero_hit) @(negedge clk);
  endtask

  task automatic wait_prd();
    @(negedge clk);
    while (!prd_hit) @(negedge clk);
  endtask

  task automatic measure(int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      h += int'(pwm_a);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int h, n, s;
    logic p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pwm_a", int'(pwm_a), 0);
    chk("R1 sync_out", int'(sync_out), 0);
    s = 0;
    for (int i = 0; i < 20; i++) begin
      s += int'(zero_hit) + int'(prd_hit);
      @(negedge clk);
    end
    chk("R1 no strobes while frozen", s, 0);

    // R5/R7 duty table, up-down, set on up, clear on down, direct writes
    wr(3, mk_ctrl(2, 1, 0, 1, 2, 1, 3));
    for (int i = 0; i < NV; i++) begin
      wr(0, VEC[i][0]);
      wr(1, VEC[i][1]);
      repeat (4 * VEC[i][0]) @(negedge clk);
      wait_zero();
      @(negedge clk);
      measure(2 * VEC[i][0], h);
      chk($sformatf("R5 R7 duty P=%0d C=%0d", VEC[i][0], VEC[i][1]), h, VEC[i][2]);
    end

    // R6 direction at turnarounds
    wait_prd();
    chk("R6 count_up at period", int'(count_up), 0);
    wait_zero();
    chk("R6 count_up at zero", int'(count_up), 1);

    // R7 compare above period keeps the output
    wr(0, 10); wr(1, 0);
    repeat (60) @(negedge clk);
    wr(1, 15);
    repeat (40) @(negedge clk);
    measure(40, h);
    chk("R7 compare above period", h, 0);

    // R4 load points: write compare 2 on a zero strobe, old compare 4
    for (int lp = 0; lp < 5; lp++) begin
      int e1, e2;
      wr(3, mk_ctrl(2, 1, 0, 1, 2, 1, 3));
      wr(1, 4);
      repeat (60) @(negedge clk);
      if (lp < 4) wr(3, mk_ctrl(2, 1, lp, 0, 2, 1, 3));
      wait_zero();
      wr(1, 2);
      measure(20, h);
      measure(20, n);
      case (lp)
        0: begin e1 = 12; e2 = 16; end
        1: begin e1 = 14; e2 = 16; end
        2: begin e1 = 14; e2 = 16; end
        3: begin e1 = 12; e2 = 12; end
        default: begin e1 = 16; e2 = 16; end
      endcase
      chk($sformatf("R4 load point %0d first window", lp), h, e1);
      chk($sformatf("R4 load point %0d second window", lp), n, e2);
    end

    // R5 separate up/down actions
    wr(3, mk_ctrl(0, 1, 0, 1, 3, 1, 3));
    wr(0, 9); wr(1, 4);
    repeat (30) @(negedge clk);
    measure(20, h);
    chk("R5 up mode toggle, down action unused", h, 10);
    chk("R6 count_up in up mode", int'(count_up), 1);
    wr(3, mk_ctrl(1, 1, 0, 1, 2, 3, 3));
    repeat (30) @(negedge clk);
    measure(20, h);
    chk("R5 down mode toggle, up action unused", h, 10);
    chk("R6 count_up in down mode", int'(count_up), 0);
    wr(3, mk_ctrl(2, 1, 0, 1, 0, 0, 3));
    p0 = pwm_a; s = 0;
    for (int i = 0; i < 40; i++) begin
      s += int'(pwm_a != p0);
      @(negedge clk);
    end
    chk("R5 action none holds output", s, 0);

    // R2 freeze one step after zero, resume in up mode
    wr(3, mk_ctrl(0, 1, 0, 1, 0, 0, 3));
    wr(0, 20);
    wait_zero();
    wr(3, mk_ctrl(3, 1, 0, 1, 0, 0, 3));
    s = 0;
    for (int i = 0; i < 30; i++) begin
      s += int'(zero_hit) + int'(prd_hit);
      @(negedge clk);
    end
    chk("R2 freeze holds counter", s, 0);
    wr(3, mk_ctrl(0, 1, 0, 1, 0, 0, 3));
    n = 1;
    while (!prd_hit) begin @(negedge clk); n++; end
    chk("R2 resume continues from frozen value", n, 20);

    // R3 period shadow versus direct
    wr(0, 9);
    wr(3, mk_ctrl(0, 0, 0, 1, 0, 0, 3));
    wait_zero();
    wr(0, 19);
    n = 1;
    while (!zero_hit) begin @(negedge clk); n++; end
    chk("R3 shadow keeps old period", n, 10);
    @(negedge clk); n = 1;
    while (!zero_hit) begin @(negedge clk); n++; end
    chk("R3 shadow loads at zero", n, 20);
    wr(3, mk_ctrl(0, 1, 0, 1, 0, 0, 3));
    wait_zero();
    wr(0, 9);
    n = 1;
    while (!zero_hit) begin @(negedge clk); n++; end
    chk("R3 direct period write", n, 10);

    // R9 sync-out selection
    wr(2, 3);
    wr(3, mk_ctrl(0, 1, 0, 1, 0, 0, 1));
    s = 0;
    for (int i = 0; i < 30; i++) begin
      s += int'(sync_out != zero_hit);
      @(negedge clk);
    end
    chk("R9 sync_out follows zero strobe", s, 0);
    wr(3, mk_ctrl(0, 1, 0, 1, 0, 0, 2));
    s = 0;
    for (int i = 0; i < 20; i++) begin
      s += int'(sync_out);
      @(negedge clk);
    end
    chk("R9 compare B pulses in 20 clocks", s, 2);
    wr(3, mk_ctrl(0, 1, 0, 1, 0, 0, 0));
    sync_in = 1'b1; #1;
    chk("R9 pass-through high", int'(sync_out), 1);
    sync_in = 1'b0; #1;
    chk("R9 pass-through low", int'(sync_out), 0);
    wr(3, mk_ctrl(0, 1, 0, 1, 0, 0, 3));
    sync_in = 1'b1; #1;
    chk("R9 disabled", int'(sync_out), 0);
    sync_in = 1'b0;

    // R8 prescale /6 * /2 with period 4
    wr(0, 4);
    wr(4, 3 | (1 << 3));
    wait_zero();
    @(negedge clk);
    chk("R6 zero strobe lasts one clock", int'(zero_hit), 0);
    wait_zero();
    @(negedge clk); n = 1;
    while (!zero_hit) begin @(negedge clk); n++; end
    chk("R8 prescaled period in clocks", n, 60);

    finish_run();
  end
endmodule